// File: doc/BRIEF.md
# RISC Integer ALU with Shifter

This block is the integer execution unit of a small load/store RISC core. Each cycle it takes two 32-bit operands, a 5-bit shift count and a 4-bit operation code. On the next clock edge it presents a 32-bit result and an overflow flag, both held in registers. The decoder in front of it chooses operands and extends immediates. A trap unit behind it decides what to do with the overflow flag.

Add and subtract come in two forms that compute the same bits. The checked form raises overflow on a two's-complement wrap. The plain form never raises it. The two less-than operations return a 0/1 word: one compares as signed integers and one compares as magnitudes. The remaining operations are bitwise AND and OR, three barrel shifts, and a placement of a 16-bit constant into the upper half of the word. Codes that are not assigned give a zero word with the flag low.

Top module: `risc_alu_core`

## Requirements
- R1: Code 0 (checked add) and code 2 (checked subtract, A minus B) give the sum or difference modulo 2^32. The overflow flag is high exactly when the true signed result lies outside -2^31 to 2^31-1.
- R2: Code 1 (plain add) and code 3 (plain subtract) give the same bits as codes 0 and 2, with the overflow flag low for any operands.
- R3: For every code other than 0 and 2, the overflow flag is low.
- R4: Code 6 (signed less-than) gives 32'd1 when A < B as two's-complement values and 32'd0 otherwise. A = 0xFFFFFFFA with B = 0x0000FFFA gives 1.
- R5: Code 7 (unsigned less-than) gives 32'd1 when A < B as unsigned values and 32'd0 otherwise. A = 0xFFFFFFFA with B = 0x0000FFFA gives 0.
- R6: Code 8 shifts A left and code 9 shifts A right, each by the 5-bit count (0 to 31), with zeros filling the vacated bits. Bits shifted out are dropped without raising overflow. For A = 0x12345678 and a count of 8, code 8 gives 0x34567800 and code 9 gives 0x00123456.
- R7: Code 10 shifts A right by the count and fills the vacated bits with A[31]. A = 0x92345678 with a count of 8 gives 0xFF923456.
- R8: Code 11 gives B[15:0] in bits 31:16 of the result and zeros in bits 15:0.
- R9: Code 4 gives A AND B and code 5 gives A OR B, bit by bit. 0x12345678 OR 0x0000FFFF gives 0x1234FFFF.
- R10: Codes 12 to 15 give a result of zero with the overflow flag low.
- R11: Result and flag are registered: the inputs sampled at one rising edge appear after that edge. A synchronous active-high reset clears both to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_sel | input | 4 | Operation code |
| opnd_a | input | 32 | First operand, also the shift source |
| opnd_b | input | 32 | Second operand; bits 15:0 feed the upper placement |
| shamt | input | 5 | Shift count |
| result | output | 32 | Registered result word |
| ovf | output | 1 | Registered signed-overflow flag |

## Verification
Every result and the overflow flag become valid one clock after the rising edge that samples the operands, and there is no deeper pipeline. The bench drives each vector on a falling edge and lets one rising edge capture it. It compares result and flag against its own behavioural model on the following falling edge, before it drives the next vector, so exactly one vector is outstanding at a time. The reset check holds reset high across a rising edge while non-zero operands are applied, then reads the outputs half a cycle later.

// File: rtl/risc_alu_pkg.sv
package risc_alu_pkg;

  localparam int WORD_W = 32;
  localparam int CNT_W  = $clog2(WORD_W);
  localparam int HALF_W = WORD_W / 2;
  localparam int CODE_W = 4;

  typedef enum logic [CODE_W-1:0] {
    OP_ADD_CHK = 4'd0,
    OP_ADD_RAW = 4'd1,
    OP_SUB_CHK = 4'd2,
    OP_SUB_RAW = 4'd3,
    OP_AND     = 4'd4,
    OP_OR      = 4'd5,
    OP_LT_S    = 4'd6,
    OP_LT_U    = 4'd7,
    OP_SHL     = 4'd8,
    OP_SHR_L   = 4'd9,
    OP_SHR_A   = 4'd10,
    OP_UPPER   = 4'd11
  } alu_op_e;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         carry,
  output logic         wrap,
  output logic         lt_signed,
  output logic         lt_unsigned
);

  logic [W-1:0] b_eff;
  logic [W:0]   wide;

  always_comb begin
    b_eff = b ^ {W{sub}};
    wide  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
    sum   = wide[W-1:0];
    carry = wide[W];
    // a wrap happens when both effective inputs share a sign that the sum lost
    wrap  = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
    // relations are only meaningful while sub is high
    lt_signed   = sum[W-1] ^ wrap;
    lt_unsigned = ~carry;
  end

endmodule

// File: rtl/alu_barrel.sv
module alu_barrel #(
  parameter int W   = 32,
  parameter int CW  = $clog2(W)
) (
  input  logic [W-1:0]  src,
  input  logic [CW-1:0] cnt,
  input  logic          go_left,
  input  logic          arith,
  output logic [W-1:0]  dst
);

  logic [W-1:0] stage [0:CW];
  logic [W-1:0] flipped_in;
  logic [W-1:0] flipped_out;
  logic         fill;

  // left shift reuses the right-shifting stages on a bit-reversed word
  generate
    for (genvar i = 0; i < W; i++) begin : g_rev
      assign flipped_in[i]  = src[W-1-i];
      assign flipped_out[i] = stage[CW][W-1-i];
    end
  endgenerate

  assign fill     = arith & ~go_left & src[W-1];
  assign stage[0] = go_left ? flipped_in : src;

  generate
    for (genvar k = 0; k < CW; k++) begin : g_stage
      localparam int D = 1 << k;
      assign stage[k+1] = cnt[k] ? {{D{fill}}, stage[k][W-1:D]} : stage[k];
    end
  endgenerate

  assign dst = go_left ? flipped_out : stage[CW];

endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise #(
  parameter int W  = 32,
  parameter int HW = 16
) (
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  input  logic [HW-1:0] konst,
  output logic [W-1:0]  and_w,
  output logic [W-1:0]  or_w,
  output logic [W-1:0]  upper_w
);

  assign and_w   = a & b;
  assign or_w    = a | b;
  assign upper_w = {konst, {(W-HW){1'b0}}};

endmodule

// File: rtl/risc_alu_core.sv
module risc_alu_core
  import risc_alu_pkg::*;
#(
  parameter int W  = WORD_W,
  parameter int CW = $clog2(W),
  parameter int HW = W / 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [3:0]    op_sel,
  input  logic [W-1:0]  opnd_a,
  input  logic [W-1:0]  opnd_b,
  input  logic [CW-1:0] shamt,
  output logic [W-1:0]  result,
  output logic          ovf
);

  alu_op_e      op;
  logic         do_sub;
  logic [W-1:0] as_sum;
  logic         as_carry;
  logic         as_wrap;
  logic         as_lts;
  logic         as_ltu;
  logic [W-1:0] sh_out;
  logic         sh_left;
  logic         sh_arith;
  logic [W-1:0] bw_and;
  logic [W-1:0] bw_or;
  logic [W-1:0] bw_upper;
  logic [W-1:0] res_d;
  logic         ovf_d;

  assign op = alu_op_e'(op_sel);

  always_comb begin
    unique case (op)
      OP_SUB_CHK, OP_SUB_RAW, OP_LT_S, OP_LT_U: do_sub = 1'b1;
      default:                                  do_sub = 1'b0;
    endcase
  end

  assign sh_left  = (op == OP_SHL);
  assign sh_arith = (op == OP_SHR_A);

  alu_addsub #(.W(W)) u_addsub (
    .a           (opnd_a),
    .b           (opnd_b),
    .sub         (do_sub),
    .sum         (as_sum),
    .carry       (as_carry),
    .wrap        (as_wrap),
    .lt_signed   (as_lts),
    .lt_unsigned (as_ltu)
  );

  alu_barrel #(.W(W), .CW(CW)) u_barrel (
    .src     (opnd_a),
    .cnt     (shamt),
    .go_left (sh_left),
    .arith   (sh_arith),
    .dst     (sh_out)
  );

  alu_bitwise #(.W(W), .HW(HW)) u_bitwise (
    .a       (opnd_a),
    .b       (opnd_b),
    .konst   (opnd_b[HW-1:0]),
    .and_w   (bw_and),
    .or_w    (bw_or),
    .upper_w (bw_upper)
  );

  always_comb begin
    res_d = '0;
    ovf_d = 1'b0;
    case (op)
      OP_ADD_CHK, OP_SUB_CHK: begin
        res_d = as_sum;
        ovf_d = as_wrap;
      end
      OP_ADD_RAW, OP_SUB_RAW: res_d = as_sum;
      OP_AND:                 res_d = bw_and;
      OP_OR:                  res_d = bw_or;
      OP_LT_S:                res_d = {{(W-1){1'b0}}, as_lts};
      OP_LT_U:                res_d = {{(W-1){1'b0}}, as_ltu};
      OP_SHL, OP_SHR_L, OP_SHR_A: res_d = sh_out;
      OP_UPPER:               res_d = bw_upper;
      default: begin
        res_d = '0;
        ovf_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      ovf    <= 1'b0;
    end else begin
      result <= res_d;
      ovf    <= ovf_d;
    end
  end

  // carry is consumed only through lt_unsigned; keep the port tied in
  logic unused_carry;
  assign unused_carry = as_carry;

endmodule

// File: rtl/risc_alu_checker.sv
module risc_alu_checker #(
  parameter int W  = 32,
  parameter int HW = 16
) (
  input logic         clk,
  input logic         rst,
  input logic [3:0]   op_sel,
  input logic [W-1:0] opnd_a,
  input logic [W-1:0] opnd_b,
  input logic [W-1:0] result,
  input logic         ovf
);

  logic seen_rst = 1'b0;
  logic armed    = 1'b0;

  always_ff @(posedge clk) begin
    if (rst) seen_rst <= 1'b1;
    armed <= ~rst;
  end

  logic live;
  assign live = seen_rst & armed;

  // R11: reset clears the outputs on the next edge
  assert_reset_clear_R11: assert property (@(posedge clk)
    rst |=> (result == '0 && !ovf));

  // R3: flag only for the checked add/subtract codes
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    (live && $past(op_sel) != 4'd0 && $past(op_sel) != 4'd2) |-> !ovf);

  // R2: plain add/subtract never raise the flag
  assert_raw_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    (live && ($past(op_sel) == 4'd1 || $past(op_sel) == 4'd3)) |-> !ovf);

  // R1: checked add yields the modular sum
  assert_add_sum_R1: assert property (@(posedge clk) disable iff (rst)
    (live && $past(op_sel) == 4'd0) |-> (result == $past(opnd_a) + $past(opnd_b)));

  // R4: signed less-than as a 0/1 word
  assert_lt_signed_R4: assert property (@(posedge clk) disable iff (rst)
    (live && $past(op_sel) == 4'd6) |->
      (result == (($signed($past(opnd_a)) < $signed($past(opnd_b))) ? 32'd1 : 32'd0)));

  // R5: unsigned less-than as a 0/1 word
  assert_lt_unsigned_R5: assert property (@(posedge clk) disable iff (rst)
    (live && $past(op_sel) == 4'd7) |->
      (result == (($past(opnd_a) < $past(opnd_b)) ? 32'd1 : 32'd0)));

  // R8: upper placement leaves low half clear
  assert_upper_place_R8: assert property (@(posedge clk) disable iff (rst)
    (live && $past(op_sel) == 4'd11) |->
      (result[HW-1:0] == '0 && result[W-1:HW] == $past(opnd_b[HW-1:0])));

  // R10: unassigned codes give zero
  assert_unused_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (live && $past(op_sel) >= 4'd12) |-> (result == '0 && !ovf));

endmodule

bind risc_alu_core risc_alu_checker #(.W(W), .HW(HW)) u_risc_alu_checker (
  .clk    (clk),
  .rst    (rst),
  .op_sel (op_sel),
  .opnd_a (opnd_a),
  .opnd_b (opnd_b),
  .result (result),
  .ovf    (ovf)
);

// File: tb/risc_alu_core_tb_top.sv
module risc_alu_core_tb_top;

  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [3:0]   op_sel = '0;
  logic [W-1:0] opnd_a = '0;
  logic [W-1:0] opnd_b = '0;
  logic [4:0]   shamt = '0;
  logic [W-1:0] result;
  logic         ovf;

  int checks   = 0;
  int failures = 0;
  logic [W-1:0] last_res;
  logic         last_ovf;

  always #4 clk = ~clk;

  risc_alu_core dut_i (
    .clk    (clk),
    .rst    (rst),
    .op_sel (op_sel),
    .opnd_a (opnd_a),
    .opnd_b (opnd_b),
    .shamt  (shamt),
    .result (result),
    .ovf    (ovf)
  );

  function automatic string req_of(input logic [3:0] op);
    case (op)
      4'd0, 4'd2:       return "R1";
      4'd1, 4'd3:       return "R2";
      4'd4, 4'd5:       return "R9";
      4'd6:             return "R4";
      4'd7:             return "R5";
      4'd8, 4'd9:       return "R6";
      4'd10:            return "R7";
      4'd11:            return "R8";
      default:          return "R10";
    endcase
  endfunction

  task automatic model(input logic [3:0] op, input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic [4:0] s, output logic [W-1:0] r, output logic o);
    longint sa, sb, t;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    r = '0;
    o = 1'b0;
    case (op)
      4'd0: begin r = a + b; t = sa + sb; o = (t > 64'sd2147483647) || (t < -64'sd2147483648); end
      4'd1: r = a + b;
      4'd2: begin r = a - b; t = sa - sb; o = (t > 64'sd2147483647) || (t < -64'sd2147483648); end
      4'd3: r = a - b;
      4'd4: r = a & b;
      4'd5: r = a | b;
      4'd6: r = (sa < sb) ? 32'd1 : 32'd0;
      4'd7: r = (a < b) ? 32'd1 : 32'd0;
      4'd8: r = a << s;
      4'd9: r = a >> s;
      4'd10: r = W'($signed(a) >>> s);
      4'd11: r = {b[15:0], 16'h0000};
      default: begin r = '0; o = 1'b0; end
    endcase
  endtask

  task automatic check(input string tag, input logic [W-1:0] got_r, input logic got_o,
                       input logic [W-1:0] exp_r, input logic exp_o);
    checks++;
    if (got_r !== exp_r || got_o !== exp_o) begin
      failures++;
      $display("FAIL %s actual=%h/%0d expected=%h/%0d", tag, got_r, got_o, exp_r, exp_o);
    end
  endtask

  // called at a falling edge; result is due after the next rising edge
  task automatic step(input logic [3:0] op, input logic [W-1:0] a, input logic [W-1:0] b,
                      input logic [4:0] s);
    logic [W-1:0] er;
    logic         eo;
    op_sel = op; opnd_a = a; opnd_b = b; shamt = s;
    model(op, a, b, s, er, eo);
    @(posedge clk);
    @(negedge clk);
    last_res = result;
    last_ovf = ovf;
    check(req_of(op), result, ovf, er, eo);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R11 reset", result, ovf, '0, 1'b0);
    rst = 1'b0;

    // doc-style literal cases
    step(4'd6, 32'hFFFFFFFA, 32'h0000FFFA, 5'd0);
    check("R4 literal", last_res, last_ovf, 32'd1, 1'b0);
    step(4'd7, 32'hFFFFFFFA, 32'h0000FFFA, 5'd0);
    check("R5 literal", last_res, last_ovf, 32'd0, 1'b0);
    step(4'd10, 32'h92345678, 32'h0, 5'd8);
    check("R7 literal", last_res, last_ovf, 32'hFF923456, 1'b0);
    step(4'd9, 32'h12345678, 32'h0, 5'd8);
    check("R6 srl literal", last_res, last_ovf, 32'h00123456, 1'b0);
    step(4'd8, 32'h12345678, 32'h0, 5'd8);
    check("R6 sll literal", last_res, last_ovf, 32'h34567800, 1'b0);
    step(4'd8, 32'hFFFFFFFF, 32'h0, 5'd31);
    check("R6 sll top drop", last_res, last_ovf, 32'h80000000, 1'b0);
    step(4'd5, 32'h12345678, 32'h0000FFFF, 5'd0);
    check("R9 or literal", last_res, last_ovf, 32'h1234FFFF, 1'b0);
    step(4'd11, 32'hDEADBEEF, 32'hAAAA1234, 5'd3);
    check("R8 literal", last_res, last_ovf, 32'h12340000, 1'b0);

    // overflow boundaries
    step(4'd0, 32'h7FFFFFFF, 32'h1, 5'd0);
    check("R1 add wrap", last_res, last_ovf, 32'h80000000, 1'b1);
    step(4'd1, 32'h7FFFFFFF, 32'h1, 5'd0);
    check("R2 add raw", last_res, last_ovf, 32'h80000000, 1'b0);
    step(4'd2, 32'h80000000, 32'h1, 5'd0);
    check("R1 sub wrap", last_res, last_ovf, 32'h7FFFFFFF, 1'b1);
    step(4'd2, 32'h0, 32'h80000000, 5'd0);
    check("R1 sub min", last_res, last_ovf, 32'h80000000, 1'b1);
    step(4'd3, 32'h0, 32'h80000000, 5'd0);
    check("R2 sub raw", last_res, last_ovf, 32'h80000000, 1'b0);
    step(4'd0, 32'h80000000, 32'h80000000, 5'd0);
    check("R1 neg wrap", last_res, last_ovf, 32'h0, 1'b1);
    step(4'd10, 32'h80000000, 32'h0, 5'd31);
    check("R7 full fill", last_res, last_ovf, 32'hFFFFFFFF, 1'b0);

    // unassigned codes with busy operands (R10), flag stays low elsewhere (R3)
    for (int c = 12; c < 16; c++) begin
      step(4'(c), 32'hFFFFFFFF, 32'h7FFFFFFF, 5'd31);
      check("R10 literal", last_res, last_ovf, 32'h0, 1'b0);
    end
    for (int c = 4; c < 12; c++) begin
      step(4'(c), 32'h7FFFFFFF, 32'h7FFFFFFF, 5'd1);
      checks++;
      if (last_ovf !== 1'b0) begin
        failures++;
        $display("FAIL R3 op=%0d actual=%0d expected=0", c, last_ovf);
      end
    end

    // R11: reset in mid-run clears outputs
    op_sel = 4'd0; opnd_a = 32'h7FFFFFFF; opnd_b = 32'h1; rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R11 mid reset", result, ovf, '0, 1'b0);
    rst = 1'b0;

    // random sweep across all codes and counts
    for (int n = 0; n < 3000; n++) begin
      logic [W-1:0] ra, rb;
      ra = $urandom();
      rb = $urandom();
      if (n % 7 == 0) ra = {ra[W-1], {(W-1){~ra[W-1]}}};
      if (n % 11 == 0) rb = ra;
      step(4'($urandom_range(0, 15)), ra, rb, 5'($urandom_range(0, 31)));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule